// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block forms the second operand of an arithmetic/logic unit together with the carry bit the shifter produces. It is purely combinational. A 32-bit input word is shifted left, shifted right logically, shifted right arithmetically or rotated right. The shift amount comes either from a 5-bit field carried in the instruction or from the low byte of a register. The current carry flag feeds the cases where the incoming carry is kept or rotated in. A third mode ignores the input word and builds an operand from an 8-bit constant, rotated right by twice a 4-bit field.

The instruction-field amount of zero does not mean "no shift" for every type. It stands for a shift by the full word width for the two right shifts, and for a one-bit rotate through carry for the rotate type. Register amounts of zero always pass the word through. Register amounts of the word width or more have fixed result and carry rules for each type. The surrounding datapath reads the registers, adjusts the program counter and runs the ALU. This block only turns its inputs into the operand and the carry-out.

Top module: `operand_shifter`

## Requirements
- R1: `kind_i` selects the type: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. For an amount n with 1 <= n <= 31 the result is the word shifted or rotated by n. Right arithmetic shifts fill with bit 31.
- R2: With `amt_from_reg_i`=1 and `reg_amt_i`=0, `operand_o` equals `value_i` and `carry_o` equals `c_i`, for every type.
- R3: With `amt_from_reg_i`=0, `imm_amt_i`=0 and type logical left, `operand_o` equals `value_i` and `carry_o` equals `c_i`.
- R4: With `amt_from_reg_i`=0 and `imm_amt_i`=0, the logical right and arithmetic right types behave as a shift by 32.
- R5: With `amt_from_reg_i`=0, `imm_amt_i`=0 and type rotate, the result is `{c_i, value_i[31:1]}` and `carry_o` is `value_i[0]`.
- R6: A logical left shift by 32 gives 0 with carry `value_i[0]`. A logical right shift by 32 gives 0 with carry `value_i[31]`. Either shift by more than 32 gives 0 with carry 0.
- R7: An arithmetic right shift by 32 or more gives 32 copies of `value_i[31]`, with carry `value_i[31]`.
- R8: A rotate by a register amount uses the amount modulo 32. A nonzero multiple of 32 returns `value_i` unchanged with carry `value_i[31]`.
- R9: For a shift or rotate by n with 1 <= n <= 31, the carry is the last bit moved out: `value_i[32-n]` for left, `value_i[n-1]` for right shifts and rotate.
- R10: With `const_mode_i`=1, `operand_o` is `{24'b0, const_i}` rotated right by 2*`rot_i`, and `carry_o` equals `c_i`.
- R11: `const_mode_i`=1 takes priority: `value_i`, `kind_i`, `amt_from_reg_i` and both amount fields have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| const_mode_i | input | 1 | Build operand from rotated constant |
| amt_from_reg_i | input | 1 | Amount from register byte (1) or instruction field (0) |
| kind_i | input | 2 | Shift type code |
| value_i | input | 32 | Word to shift |
| imm_amt_i | input | 5 | Instruction-field shift amount |
| reg_amt_i | input | 8 | Register-supplied shift amount |
| const_i | input | 8 | Constant for immediate-operand mode |
| rot_i | input | 4 | Half the rotate amount for the constant |
| c_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Every type is swept over register amounts 0 to 40, 64, 128 and 255, and over all 32 field amounts. Each sweep uses several words with different top and bottom bits, and both carry-in values. The word patterns keep bit 0, bit 31 and the inner bits distinct, so a wrong carry bit index, a wrong fill, or a swapped width-boundary rule shows up. Running with both carry-in values separates pass-through and rotate-through-carry results from true shifts. The constant mode is swept over every rotate field with unrelated values driven on the ignored inputs, which exposes any leak from the shifter path.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shf_kind_e;

    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_LSL  = 3'd1,
        OP_LSR  = 3'd2,
        OP_ASR  = 3'd3,
        OP_ROR  = 3'd4,
        OP_RRX  = 3'd5
    } shf_op_e;

    // Plain mapping of a type code onto the engine operation.
    function automatic shf_op_e kind_to_op(input shf_kind_e k);
        case (k)
            SK_LSL:  return OP_LSL;
            SK_LSR:  return OP_LSR;
            SK_ASR:  return OP_ASR;
            default: return OP_ROR;
        endcase
    endfunction

endpackage

// File: rtl/shf_decode.sv
module shf_decode
    import shf_pkg::*;
#(
    parameter int W         = 32,
    parameter int IMM_AMT_W = 5,
    parameter int REG_AMT_W = 8
) (
    input  logic                 amt_from_reg_i,
    input  shf_kind_e            kind_i,
    input  logic [IMM_AMT_W-1:0] imm_amt_i,
    input  logic [REG_AMT_W-1:0] reg_amt_i,
    output shf_op_e              op_o,
    output logic [REG_AMT_W-1:0] amt_o
);
    localparam logic [REG_AMT_W-1:0] FULL = REG_AMT_W'(W);

    always_comb begin
        op_o  = kind_to_op(kind_i);
        amt_o = '0;
        if (amt_from_reg_i) begin
            amt_o = reg_amt_i;
            if (reg_amt_i == '0) op_o = OP_PASS;
        end else begin
            amt_o = REG_AMT_W'(imm_amt_i);
            if (imm_amt_i == '0) begin
                case (kind_i)
                    SK_LSL:  op_o = OP_PASS;
                    SK_ROR:  op_o = OP_RRX;
                    default: amt_o = FULL;
                endcase
            end
        end
    end
endmodule

// File: rtl/shf_engine.sv
module shf_engine
    import shf_pkg::*;
#(
    parameter int W         = 32,
    parameter int REG_AMT_W = 8
) (
    input  shf_op_e              op_i,
    input  logic [REG_AMT_W-1:0] amt_i,
    input  logic [W-1:0]         value_i,
    input  logic                 c_i,
    output logic [W-1:0]         res_o,
    output logic                 carry_o
);
    localparam int LOG_W = $clog2(W);

    // Each shifter keeps one extra bit that catches the last bit moved out.
    logic [W:0]          lsl_t;
    logic [W:0]          lsr_t;
    logic signed [W:0]   asr_t;
    logic [2*W-1:0]      ror_t;

    always_comb begin
        lsl_t = {1'b0, value_i} << amt_i;
        lsr_t = {value_i, 1'b0} >> amt_i;
        asr_t = $signed({value_i, 1'b0}) >>> amt_i;
        ror_t = {value_i, value_i} >> amt_i[LOG_W-1:0];
    end

    always_comb begin
        res_o   = value_i;
        carry_o = c_i;
        case (op_i)
            OP_LSL: begin
                res_o   = lsl_t[W-1:0];
                carry_o = lsl_t[W];
            end
            OP_LSR: begin
                res_o   = lsr_t[W:1];
                carry_o = lsr_t[0];
            end
            OP_ASR: begin
                res_o   = asr_t[W:1];
                carry_o = asr_t[0];
            end
            OP_ROR: begin
                res_o   = ror_t[W-1:0];
                carry_o = ror_t[W-1];
            end
            OP_RRX: begin
                res_o   = {c_i, value_i[W-1:1]};
                carry_o = value_i[0];
            end
            default: begin
                res_o   = value_i;
                carry_o = c_i;
            end
        endcase
    end
endmodule

// File: rtl/shf_constrot.sv
module shf_constrot #(
    parameter int W     = 32,
    parameter int K_W   = 8,
    parameter int ROT_W = 4
) (
    input  logic [K_W-1:0]   const_i,
    input  logic [ROT_W-1:0] rot_i,
    output logic [W-1:0]     res_o
);
    localparam int PAD = W - K_W;

    logic [W-1:0]   wide;
    logic [2*W-1:0] both;

    always_comb begin
        wide  = {{PAD{1'b0}}, const_i};
        both  = {wide, wide} >> {rot_i, 1'b0};
        res_o = both[W-1:0];
    end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
    import shf_pkg::*;
#(
    parameter int W         = 32,
    parameter int IMM_AMT_W = 5,
    parameter int REG_AMT_W = 8,
    parameter int K_W       = 8,
    parameter int ROT_W     = 4
) (
    input  logic                 const_mode_i,
    input  logic                 amt_from_reg_i,
    input  logic [1:0]           kind_i,
    input  logic [W-1:0]         value_i,
    input  logic [IMM_AMT_W-1:0] imm_amt_i,
    input  logic [REG_AMT_W-1:0] reg_amt_i,
    input  logic [K_W-1:0]       const_i,
    input  logic [ROT_W-1:0]     rot_i,
    input  logic                 c_i,
    output logic [W-1:0]         operand_o,
    output logic                 carry_o
);
    shf_op_e              op;
    logic [REG_AMT_W-1:0] amt;
    logic [W-1:0]         sh_res;
    logic                 sh_carry;
    logic [W-1:0]         k_res;

    shf_decode #(.W(W), .IMM_AMT_W(IMM_AMT_W), .REG_AMT_W(REG_AMT_W)) u_dec (
        .amt_from_reg_i (amt_from_reg_i),
        .kind_i         (shf_kind_e'(kind_i)),
        .imm_amt_i      (imm_amt_i),
        .reg_amt_i      (reg_amt_i),
        .op_o           (op),
        .amt_o          (amt)
    );

    shf_engine #(.W(W), .REG_AMT_W(REG_AMT_W)) u_eng (
        .op_i    (op),
        .amt_i   (amt),
        .value_i (value_i),
        .c_i     (c_i),
        .res_o   (sh_res),
        .carry_o (sh_carry)
    );

    shf_constrot #(.W(W), .K_W(K_W), .ROT_W(ROT_W)) u_krot (
        .const_i (const_i),
        .rot_i   (rot_i),
        .res_o   (k_res)
    );

    always_comb begin
        if (const_mode_i) begin
            operand_o = k_res;
            carry_o   = c_i;
        end else begin
            operand_o = sh_res;
            carry_o   = sh_carry;
        end
    end
endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
    parameter int W         = 32,
    parameter int IMM_AMT_W = 5,
    parameter int REG_AMT_W = 8,
    parameter int K_W       = 8,
    parameter int ROT_W     = 4
) (
    input logic                 const_mode_i,
    input logic                 amt_from_reg_i,
    input logic [1:0]           kind_i,
    input logic [W-1:0]         value_i,
    input logic [IMM_AMT_W-1:0] imm_amt_i,
    input logic [REG_AMT_W-1:0] reg_amt_i,
    input logic [K_W-1:0]       const_i,
    input logic [ROT_W-1:0]     rot_i,
    input logic                 c_i,
    input logic [W-1:0]         operand_o,
    input logic                 carry_o
);
    logic known;
    logic sh_path;

    always_comb begin
        known   = !$isunknown({const_mode_i, amt_from_reg_i, kind_i, value_i,
                               imm_amt_i, reg_amt_i, const_i, rot_i, c_i});
        sh_path = known && !const_mode_i;

        if (sh_path && amt_from_reg_i && reg_amt_i == '0)
            a_r2_regzero_pass: assert (operand_o == value_i && carry_o == c_i)
                else $error("R2 zero register amount altered word");

        if (sh_path && !amt_from_reg_i && imm_amt_i == '0 && kind_i == 2'd3)
            a_r5_rrx: assert (operand_o[W-2:0] == value_i[W-1:1] &&
                              operand_o[W-1] == c_i && carry_o == value_i[0])
                else $error("R5 rotate through carry wrong");

        if (sh_path && amt_from_reg_i && kind_i == 2'd0 && reg_amt_i > REG_AMT_W'(W))
            a_r6_lsl_over: assert (operand_o == '0 && !carry_o)
                else $error("R6 left shift beyond width not cleared");

        if (sh_path && amt_from_reg_i && kind_i == 2'd2 && reg_amt_i >= REG_AMT_W'(W))
            a_r7_asr_fill: assert (operand_o == {W{value_i[W-1]}} && carry_o == value_i[W-1])
                else $error("R7 arithmetic fill wrong");

        if (known && const_mode_i)
            a_r10_const_bits: assert (carry_o == c_i &&
                                      $countones(operand_o) == $countones(const_i))
                else $error("R10 constant operand wrong");
    end
endmodule

bind operand_shifter operand_shifter_chk #(
    .W(W), .IMM_AMT_W(IMM_AMT_W), .REG_AMT_W(REG_AMT_W), .K_W(K_W), .ROT_W(ROT_W)
) u_chk (
    .const_mode_i   (const_mode_i),
    .amt_from_reg_i (amt_from_reg_i),
    .kind_i         (kind_i),
    .value_i        (value_i),
    .imm_amt_i      (imm_amt_i),
    .reg_amt_i      (reg_amt_i),
    .const_i        (const_i),
    .rot_i          (rot_i),
    .c_i            (c_i),
    .operand_o      (operand_o),
    .carry_o        (carry_o)
);

// File: tb/operand_shifter_test.sv
module operand_shifter_test;

    logic        clk = 1'b0;
    logic        const_mode_i;
    logic        amt_from_reg_i;
    logic [1:0]  kind_i;
    logic [31:0] value_i;
    logic [4:0]  imm_amt_i;
    logic [7:0]  reg_amt_i;
    logic [7:0]  const_i;
    logic [3:0]  rot_i;
    logic        c_i;
    logic [31:0] operand_o;
    logic        carry_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    operand_shifter uut (
        .const_mode_i   (const_mode_i),
        .amt_from_reg_i (amt_from_reg_i),
        .kind_i         (kind_i),
        .value_i        (value_i),
        .imm_amt_i      (imm_amt_i),
        .reg_amt_i      (reg_amt_i),
        .const_i        (const_i),
        .rot_i          (rot_i),
        .c_i            (c_i),
        .operand_o      (operand_o),
        .carry_o        (carry_o)
    );

    logic [31:0] pats [6] = '{32'h0000_0000, 32'h8000_0001, 32'hF0F0_A55A,
                              32'h7FFF_FFFE, 32'h1234_5678, 32'hC000_0002};

    // Expected value from the written rules, shift-type by shift-type.
    task automatic model(input bit kmode, input bit fromreg, input int kind,
                         input logic [31:0] v, input int iamt, input int ramt,
                         input logic [7:0] k, input int rot, input bit c,
                         output logic [31:0] er, output bit ec, output string tag);
        int n;
        if (kmode) begin
            int r2 = 2 * rot;
            logic [31:0] kw = {24'b0, k};
            er  = (r2 == 0) ? kw : ((kw >> r2) | (kw << (32 - r2)));
            ec  = c;
            tag = "R10 R11";
            return;
        end
        if (fromreg) begin
            n = ramt;
            if (n == 0) begin er = v; ec = c; tag = "R2"; return; end
        end else begin
            n = iamt;
            if (n == 0) begin
                if (kind == 0) begin er = v; ec = c; tag = "R3"; return; end
                if (kind == 3) begin
                    er = {c, v[31:1]}; ec = v[0]; tag = "R5"; return;
                end
                n = 32;
            end
        end
        tag = "R1 R9";
        if (!fromreg && iamt == 0) tag = "R4";
        case (kind)
            0: begin
                if (n < 32) begin er = v << n; ec = v[32-n]; end
                else begin
                    er = 0; ec = (n == 32) ? v[0] : 1'b0;
                    if (tag != "R4") tag = "R6";
                end
            end
            1: begin
                if (n < 32) begin er = v >> n; ec = v[n-1]; end
                else begin
                    er = 0; ec = (n == 32) ? v[31] : 1'b0;
                    if (tag != "R4") tag = "R6";
                end
            end
            2: begin
                if (n < 32) begin
                    er = v >> n;
                    for (int b = 0; b < n; b++) er[31-b] = v[31];
                    ec = v[n-1];
                end else begin
                    er = {32{v[31]}}; ec = v[31];
                    if (tag != "R4") tag = "R7";
                end
            end
            default: begin
                int m = n % 32;
                if (n >= 32) tag = "R8";
                if (m == 0) begin er = v; ec = v[31]; end
                else begin er = (v >> m) | (v << (32 - m)); ec = v[m-1]; end
            end
        endcase
    endtask

    task automatic run(input bit kmode, input bit fromreg, input int kind,
                       input logic [31:0] v, input int iamt, input int ramt,
                       input logic [7:0] k, input int rot, input bit c);
        logic [31:0] er;
        bit          ec;
        string       tag;
        @(posedge clk);
        #2;
        const_mode_i   = kmode;
        amt_from_reg_i = fromreg;
        kind_i         = 2'(kind);
        value_i        = v;
        imm_amt_i      = 5'(iamt);
        reg_amt_i      = 8'(ramt);
        const_i        = k;
        rot_i          = 4'(rot);
        c_i            = c;
        model(kmode, fromreg, kind, v, iamt, ramt, k, rot, c, er, ec, tag);
        @(negedge clk);
        n_checks++;
        if (operand_o !== er || carry_o !== ec) begin
            n_fail++;
            $display("FAIL %s: kind=%0d reg=%0b amt=%0d/%0d val=%h -> got %h/%0b expected %h/%0b",
                     tag, kind, fromreg, iamt, ramt, v, operand_o, carry_o, er, ec);
        end
    endtask

    initial begin
        // Idle-state check: all-zero inputs give zero operand and zero carry (R2).
        run(0, 1, 0, 32'h0, 0, 0, 8'h0, 0, 0);

        // Register-supplied amounts: R1 R2 R6 R7 R8 R9.
        for (int kd = 0; kd < 4; kd++)
            for (int p = 0; p < 6; p++)
                for (int c = 0; c < 2; c++) begin
                    for (int a = 0; a <= 40; a++) run(0, 1, kd, pats[p], 0, a, 8'h0, 0, c[0]);
                    run(0, 1, kd, pats[p], 0, 64,  8'h0, 0, c[0]);
                    run(0, 1, kd, pats[p], 0, 128, 8'h0, 0, c[0]);
                    run(0, 1, kd, pats[p], 0, 255, 8'h0, 0, c[0]);
                end

        // Instruction-field amounts: R3 R4 R5 and normal shifts.
        for (int kd = 0; kd < 4; kd++)
            for (int p = 0; p < 6; p++)
                for (int c = 0; c < 2; c++)
                    for (int a = 0; a < 32; a++)
                        run(0, 0, kd, pats[p], a, 255 - a, 8'h0, 0, c[0]);

        // Constant mode with unrelated values on ignored inputs: R10 R11.
        for (int q = 0; q < 5; q++)
            for (int r = 0; r < 16; r++)
                for (int c = 0; c < 2; c++) begin
                    logic [7:0] kk;
                    case (q)
                        0: kk = 8'h01;
                        1: kk = 8'h80;
                        2: kk = 8'hA5;
                        3: kk = 8'hFF;
                        default: kk = 8'h3C;
                    endcase
                    run(1, r[0], r % 4, pats[(q + r) % 6], r + q, 7 * r, kk, r, c[0]);
                end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule